// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital timing and control core of a 12-bit successive-approximation converter that has a three-wire serial port. A single system clock samples the serial clock, the convert strobe, the shutdown pin, a channel select and a bipolar/unipolar select. The block drives the track/hold switch and the analog bias enable, and it presents a trial word to the capacitor DAC. One comparator decision per serial clock falling edge comes back, and each resolved bit goes out on the serial data line as soon as it is known.

After reset the block is fully powered down. A rising convert strobe wakes it and starts tracking. A falling strobe freezes the sample and latches the channel and coding selection. The next twelve serial clock falling edges each resolve one bit, MSB first. The thirteenth falling edge returns the block to tracking. A strobe that rises early abandons the conversion. Shutdown forces power-down from any state.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, `analog_on`, `th_track` and `dout` are 0. Serial clock activity does not change them until `cnvst` rises.
- R2: While powered down with `shdn` low, a rising `cnvst` sets `analog_on` and `th_track` to 1 (tracking).
- R3: While tracking, a falling `cnvst` sets `th_track` to 0 (hold) and loads `dac_word` with only its MSB set (0x800).
- R4: Each of the first 12 `sclk` falling edges in a conversion resolves one bit, MSB first. A bit stays 1 when `cmp_hi`=1 (input at or above the trial word) and is cleared otherwise, and the next lower bit is then set as the trial. After the 12th edge `dac_word` holds the result.
- R5: `dout` is 0 from the `cnvst` fall until the first `sclk` fall. After falling edge k (k = 1..12) it carries result bit 12-k. It is 0 whenever no conversion is running.
- R6: The 13th `sclk` falling edge sets `th_track` to 1 and `dout` to 0. Further `sclk` edges while tracking change neither.
- R7: `chan_sel` and `bip_mode` are captured on the `cnvst` fall onto `sel_chan` and `sel_bip`. Changes to those inputs during a conversion have no effect on these outputs.
- R8: With `bip_mode`=1 (bipolar), the first bit on `dout` is the inverted MSB, which gives two's complement. With `bip_mode`=0, all bits are straight binary.
- R9: `shdn`=1 forces power-down within one clock from any state (`analog_on`, `th_track` and `dout` are 0) and blocks waking while it stays high.
- R10: A rising `cnvst` before the 13th `sclk` falling edge abandons the conversion: `th_track` goes to 1 and `dout` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; falling edges step the conversion |
| cnvst | input | 1 | Convert strobe; rise wakes or tracks, fall samples |
| shdn | input | 1 | Forces full power-down while high |
| chan_sel | input | 1 | Differential input channel select |
| bip_mode | input | 1 | 1 = bipolar (two's complement), 0 = unipolar |
| cmp_hi | input | 1 | Comparator decision: input is at or above the trial word |
| analog_on | output | 1 | Analog bias enable, 0 in full power-down |
| th_track | output | 1 | Track/hold control, 1 = track, 0 = hold |
| sel_chan | output | 1 | Channel latched for the current sample |
| sel_bip | output | 1 | Coding mode latched for the current sample |
| dac_word | output | 12 | Trial word driven to the capacitor DAC |
| dout | output | 1 | Serial result, MSB first |

## Verification
Each control input is registered once for edge detection, and the state update happens on that same clock. Every response is therefore visible on the first rising clock edge after the input changes. The bench changes its inputs on a falling clock edge and samples on the next falling edge, which places each check half a clock after the register that produces its result. The comparator is modeled from the `dac_word` port against a stimulus value, so that each edge's decision applies to the trial word that is present when the edge is detected. The expected serial bits and the final word are computed by bench functions from the stimulus value and the coding mode.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    localparam int DEF_RES_BITS = 12;
    localparam int DEF_NUM_CH   = 2;

    typedef enum logic [1:0] {
        ST_PWRDN = 2'b00,
        ST_ACQ   = 2'b01,
        ST_CONV  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic start;   // enter conversion, load first trial
        logic step;    // resolve one bit on this serial edge
        logic finish;  // final serial edge, back to tracking
        logic clear;   // force serial output low
    } sar_ctl_t;

    typedef struct packed {
        logic bip;
        logic chan;
    } conv_cfg_t;

    // Serial bit as transmitted: MSB is inverted in bipolar coding.
    function automatic logic coded_bit(input logic decided, input logic bip,
                                       input logic first);
        return decided ^ (bip & first);
    endfunction

endpackage

// File: rtl/sarseq_edge.sv
module sarseq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] sig_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sig_q[i] <= 1'b0;
            else     sig_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~sig_q[i];
        assign fall[i] = ~sig[i] & sig_q[i];
    end
endmodule

// File: rtl/sarseq_fsm.sv
module sarseq_fsm
    import sarseq_pkg::*;
#(
    parameter int RES_BITS = DEF_RES_BITS,
    parameter int CNT_W    = $clog2(RES_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn,
    input  logic             cnvst_rise,
    input  logic             cnvst_fall,
    input  logic             sclk_fall,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output sar_ctl_t         ctl
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RES_BITS);

    logic conv_edge;
    logic abort;

    assign abort     = (state == ST_CONV) && cnvst_rise && !shdn;
    assign conv_edge = (state == ST_CONV) && sclk_fall && !cnvst_rise && !shdn;

    always_comb begin
        ctl        = '0;
        ctl.start  = (state == ST_ACQ) && cnvst_fall && !shdn;
        ctl.step   = conv_edge && (cnt < LAST_CNT);
        ctl.finish = conv_edge && (cnt == LAST_CNT);
        ctl.clear  = shdn || abort || ctl.finish || ctl.start;
    end

    always_ff @(posedge clk) begin
        if (rst || shdn) begin
            state <= ST_PWRDN;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_PWRDN: if (cnvst_rise) state <= ST_ACQ;
                ST_ACQ: if (cnvst_fall) begin
                    state <= ST_CONV;
                    cnt   <= '0;
                end
                ST_CONV: begin
                    if (cnvst_rise) begin
                        state <= ST_ACQ;
                    end else if (sclk_fall) begin
                        if (cnt == LAST_CNT) state <= ST_ACQ;
                        else                 cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= ST_PWRDN;
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_CNT);                                                  // R4
    AST_SHDN_PWRDN: assert property (@(posedge clk) disable iff (rst)
        shdn |=> state == ST_PWRDN);                                       // R9
    AST_WAKE_ACQ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRDN && cnvst_rise && !shdn) |=> state == ST_ACQ);   // R2
    AST_FINISH_ACQ: assert property (@(posedge clk) disable iff (rst)
        (ctl.finish && !shdn) |=> state == ST_ACQ);                        // R6
    AST_ABORT_ACQ: assert property (@(posedge clk) disable iff (rst)
        abort |=> state == ST_ACQ);                                        // R10
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar
    import sarseq_pkg::*;
#(
    parameter int RES_BITS = DEF_RES_BITS,
    parameter int CNT_W    = $clog2(RES_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  sar_ctl_t            ctl,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] word
);
    localparam logic [RES_BITS-1:0] FIRST_TRIAL = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [CNT_W-1:0] idx;
    assign idx = CNT_W'(RES_BITS - 1) - cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (ctl.start) begin
            word <= FIRST_TRIAL;
        end else if (ctl.step) begin
            for (int i = 0; i < RES_BITS; i++) begin
                if (int'(idx) == i)          word[i] <= cmp_hi;
                else if (int'(idx) == i + 1) word[i] <= 1'b1;
            end
        end
    end

    AST_SAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctl.start |=> word == FIRST_TRIAL);                                // R3
    AST_SAR_DECIDE: assert property (@(posedge clk) disable iff (rst)
        ctl.step |=> word[$past(idx)] == $past(cmp_hi));                   // R4
endmodule

// File: rtl/sarseq_shift.sv
module sarseq_shift
    import sarseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sar_ctl_t ctl,
    input  logic     first,
    input  logic     bip,
    input  logic     cmp_hi,
    output logic     dout
);
    always_ff @(posedge clk) begin
        if (rst || ctl.clear)  dout <= 1'b0;
        else if (ctl.step)     dout <= coded_bit(cmp_hi, bip, first);
    end

    AST_DOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> !dout);                                              // R5
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clear && !ctl.step) |=> $stable(dout));                      // R5
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sarseq_pkg::*;
#(
    parameter int RES_BITS = DEF_RES_BITS,
    localparam int CNT_W   = $clog2(RES_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                cnvst,
    input  logic                shdn,
    input  logic                chan_sel,
    input  logic                bip_mode,
    input  logic                cmp_hi,
    output logic                analog_on,
    output logic                th_track,
    output logic                sel_chan,
    output logic                sel_bip,
    output logic [RES_BITS-1:0] dac_word,
    output logic                dout
);
    logic [1:0]       rise, fall;
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    sar_ctl_t         ctl;
    conv_cfg_t        cfg;

    // bit 1 = cnvst, bit 0 = sclk
    sarseq_edge #(.N(2)) u_edge (
        .clk(clk), .rst(rst), .sig({cnvst, sclk}), .rise(rise), .fall(fall)
    );

    sarseq_fsm #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .shdn(shdn),
        .cnvst_rise(rise[1]), .cnvst_fall(fall[1]), .sclk_fall(fall[0]),
        .state(state), .cnt(cnt), .ctl(ctl)
    );

    sarseq_sar #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_sar (
        .clk(clk), .rst(rst), .ctl(ctl), .cnt(cnt), .cmp_hi(cmp_hi),
        .word(dac_word)
    );

    sarseq_shift u_shift (
        .clk(clk), .rst(rst), .ctl(ctl), .first(cnt == '0),
        .bip(cfg.bip), .cmp_hi(cmp_hi), .dout(dout)
    );

    always_ff @(posedge clk) begin
        if (rst)            cfg <= '0;
        else if (ctl.start) cfg <= '{bip: bip_mode, chan: chan_sel};
    end

    assign analog_on = (state != ST_PWRDN);
    assign th_track  = (state == ST_ACQ);
    assign sel_chan  = cfg.chan;
    assign sel_bip   = cfg.bip;

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CONV) |-> !dout);                                     // R5
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && $past(state == ST_CONV)) |-> $stable(cfg));   // R7
    AST_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (th_track && fall[1] && !shdn) |=> !th_track);                     // R3
    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !analog_on |-> (!th_track && !dout));                              // R1
endmodule

// File: tb/tb_sar_conv_sequencer.sv
`timescale 1ns/1ps
module tb_sar_conv_sequencer;
    logic        clk = 1'b0;
    logic        rst;
    logic        sclk, cnvst, shdn, chan_sel, bip_mode, cmp_hi;
    logic        analog_on, th_track, sel_chan, sel_bip, dout;
    logic [11:0] dac_word;
    logic [11:0] stim;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;  // 125 MHz

    // Comparator model: analog input at or above trial word keeps the bit.
    assign cmp_hi = (dac_word <= stim);

    sar_conv_sequencer dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cnvst(cnvst), .shdn(shdn),
        .chan_sel(chan_sel), .bip_mode(bip_mode), .cmp_hi(cmp_hi),
        .analog_on(analog_on), .th_track(th_track), .sel_chan(sel_chan),
        .sel_bip(sel_bip), .dac_word(dac_word), .dout(dout)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [11:0] v, input logic bp, input int k);
        logic b;
        b = v[12-k];
        if (k == 1 && bp) b = ~b;
        return b;
    endfunction

    // Runs one conversion. abort_at/shdn_at: edge after which cnvst rises / shdn asserts (0 = never).
    task automatic convert(input logic [11:0] v, input logic ch, input logic bp,
                           input int abort_at, input int shdn_at);
        stim = v; chan_sel = ch; bip_mode = bp;
        cnvst = 1'b1; tick(3);
        chk("R2 track", {analog_on, th_track}, 2'b11);
        cnvst = 1'b0; tick(1);
        chk("R3 hold", th_track, 1'b0);
        chk("R3 first trial", dac_word, 32'h800);
        chk("R5 dout low before first edge", dout, 1'b0);
        chk("R7 latched", {sel_chan, sel_bip}, {ch, bp});
        chan_sel = ~ch; bip_mode = ~bp;
        for (int k = 1; k <= 13; k++) begin
            sclk = 1'b1; tick(2);
            sclk = 1'b0; tick(1);
            if (k <= 12) begin
                chk(bp ? "R8 R5 bipolar bit" : "R8 R5 unipolar bit", dout, exp_bit(v, bp, k));
                chk("R7 held", {sel_chan, sel_bip}, {ch, bp});
            end
            if (k == 12) chk("R4 result word", dac_word, v);
            if (k == 13) chk("R6 back to track", {th_track, dout}, 2'b10);
            if (k == abort_at) begin
                cnvst = 1'b1; tick(1);
                chk("R10 abort", {th_track, dout}, 2'b10);
                return;
            end
            if (k == shdn_at) begin
                shdn = 1'b1; tick(1);
                chk("R9 shutdown", {analog_on, th_track, dout}, 3'b000);
                return;
            end
            tick(1);
        end
        // extra serial edges while tracking
        for (int j = 0; j < 2; j++) begin
            sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
            chk("R6 idle edges ignored", {th_track, dout}, 2'b10);
        end
    endtask

    initial begin
        logic [11:0] corner [4];
        void'($urandom(32'h5A17));
        rst = 1'b1; sclk = 0; cnvst = 0; shdn = 0; chan_sel = 0; bip_mode = 0; stim = '0;
        tick(3);
        rst = 1'b0; tick(1);
        chk("R1 reset state", {analog_on, th_track, dout}, 3'b000);
        for (int j = 0; j < 3; j++) begin
            sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
        end
        chk("R1 stays powered down", {analog_on, th_track, dout}, 3'b000);

        corner = '{12'h000, 12'hFFF, 12'h800, 12'h7FF};
        for (int i = 0; i < 4; i++) begin
            convert(corner[i], 1'b0, 1'b0, 0, 0);
            convert(corner[i], 1'b1, 1'b1, 0, 0);
        end
        for (int i = 0; i < 40; i++)
            convert(12'($urandom), 1'($urandom), 1'($urandom), 0, 0);

        // R10: early strobe, then a clean conversion follows
        convert(12'hFFF, 1'b0, 1'b0, 4, 0);
        convert(12'hA5C, 1'b1, 1'b0, 0, 0);

        // R9: shutdown mid-conversion while dout would be high
        convert(12'hFFF, 1'b1, 1'b1, 0, 5);
        cnvst = 1'b0; tick(2);
        cnvst = 1'b1; tick(2);
        chk("R9 no wake while shut down", {analog_on, th_track}, 2'b00);
        shdn = 1'b0; tick(2);
        chk("R9 stays down after release", analog_on, 1'b0);
        cnvst = 1'b0; tick(2);
        convert(12'h3C6, 1'b0, 1'b1, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule